// File: doc/BRIEF.md
# Dual-Line ADC Serial Readout Emulator

This block stands in for the output side of a two-channel successive-approximation converter, for use as synthesizable test logic. A falling edge on the conversion-start input raises a busy flag for a fixed number of system clock cycles. When busy drops, the block captures two 12-bit channel results from its inputs. A host then reads those results through a chip-select and serial-clock pair. Each channel has its own data line and output enable, and the line is treated as high impedance whenever its enable is low.

The host can read both channels in parallel, one per line, with 12 serial clocks. It can also keep chip select low for 24 clocks and take both results from a single line: the first line gives channel A then channel B, and the second line gives channel B then channel A.

The host signals are asynchronous to the system clock. Each one passes through a two-flop synchronizer and then an edge detector, so every host edge takes effect on the third rising system clock edge after it occurs.

Top module: `adc_port_emu`

## Requirements
- R1: A falling edge on `convst_n_i` sets `busy_o` high on the third system clock edge after the fall, and `busy_o` then stays high for exactly `CONV_CYCLES` system cycles.
- R2: A chip-select fall sets both `oe_a_o` and `oe_b_o` high. At the same time it puts bit 11 of result A on `dout_a_o` and bit 11 of result B on `dout_b_o`.
- R3: Each later serial-clock fall moves both lines to the next lower bit, most significant bit first.
- R4: A serial-clock fall detected in the same system cycle as the chip-select fall is ignored, so the MSB stays on the line until the next serial-clock fall.
- R5: While chip select stays low, serial-clock falls 12 to 23 present the other channel's result, MSB first: B on the first line and A on the second line.
- R6: A chip-select rise drives both enables low and both data lines to 0.
- R7: Chip select may fall while `busy_o` is high. The lines are then driven at once with the results latched by the previous conversion.
- R8: After 24 bits have been shifted, further serial-clock falls with chip select low drive 0 on both lines while the enables stay high.
- R9: A conversion-start fall that arrives while `busy_o` is high is ignored and does not lengthen the busy period.
- R10: The results are captured from `res_a_i` and `res_b_i` on the cycle in which `busy_o` falls. Later changes on those inputs do not affect the data that is read out.
- R11: After reset, `busy_o` and both enables are low, and the latched results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convst_n_i | input | 1 | Conversion start; its falling edge begins a conversion |
| cs_n_i | input | 1 | Active-low chip select from the host |
| sclk_i | input | 1 | Serial clock from the host; bits advance on falling edges |
| res_a_i | input | RES_W | Channel A result, captured at the end of a conversion |
| res_b_i | input | RES_W | Channel B result, captured at the end of a conversion |
| busy_o | output | 1 | High while a conversion is in progress |
| dout_a_o | output | 1 | First data line |
| oe_a_o | output | 1 | Drive enable of the first data line (low means high impedance) |
| dout_b_o | output | 1 | Second data line |
| oe_b_o | output | 1 | Drive enable of the second data line (low means high impedance) |

## Verification
The assertions assume that each host signal is held for several system clocks between transitions, so that every edge appears exactly once after synchronization. They also assume that chip select never rises and falls within the same synchronized cycle. The stimulus changes host inputs only on falling system clock edges and holds every level for at least four cycles. The one exception is the deliberate case where chip select and the serial clock fall on the same cycle. Conversion-start pulses are kept wide enough to be seen, including the pulse sent while busy is high.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    // Positions of the host signals inside the synchronizer vector
    localparam int IDX_CS   = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_CONV = 2;
    localparam int N_HOST   = 3;

    // Edge events seen in the system clock domain
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sclk_fall;
        logic conv_fall;
    } port_ev_t;

endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    // Stage 0..STAGES-1 form the synchronizer, stage STAGES is the edge history
    typedef struct packed {
        logic [STAGES:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = in_i;
        for (int k = 1; k <= STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;  // host signals idle high
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.chain[STAGES-1];
    assign prev_o = st_q.chain[STAGES];

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_fall_i,
    input  logic [RES_W-1:0] res_a_i,
    input  logic [RES_W-1:0] res_b_i,
    output logic             busy_o,
    output logic [RES_W-1:0] lat_a_o,
    output logic [RES_W-1:0] lat_b_o
);

    localparam int TW = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES + 1);
    localparam logic [TW-1:0] LOAD = TW'(CONV_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [TW-1:0]    left;
        logic [RES_W-1:0] lat_a;
        logic [RES_W-1:0] lat_b;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.left == '0) begin
                // conversion complete: release busy and capture the results
                st_d.busy  = 1'b0;
                st_d.lat_a = res_a_i;
                st_d.lat_b = res_b_i;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end else if (conv_fall_i) begin
            st_d.busy = 1'b1;
            st_d.left = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign lat_a_o = st_q.lat_a;
    assign lat_b_o = st_q.lat_b;

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(conv_fall_i)) else $error("busy rose without start"); // R1

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.left != '0 && conv_fall_i) |=> (st_q.busy && st_q.left == $past(st_q.left) - 1'b1))
        else $error("start during busy changed timer"); // R9

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> ($stable(st_q.lat_a) && $stable(st_q.lat_b)))
        else $error("latched results changed while idle"); // R10

endmodule

// File: rtl/adc_port_shifter.sv
module adc_port_shifter #(
    parameter int RES_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  adc_port_pkg::port_ev_t  ev_i,
    input  logic [RES_W-1:0]        lat_a_i,
    input  logic [RES_W-1:0]        lat_b_i,
    output logic                    dout_a_o,
    output logic                    oe_a_o,
    output logic                    dout_b_o,
    output logic                    oe_b_o
);

    localparam int FRAME = 2 * RES_W;
    localparam int CW    = $clog2(FRAME + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(FRAME);

    typedef struct packed {
        logic             active;
        logic [CW-1:0]    cnt;
        logic [FRAME-1:0] sh_a;
        logic [FRAME-1:0] sh_b;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev_i.cs_rise) begin
            st_d = '0;
        end else if (ev_i.cs_fall) begin
            // a serial clock fall in this same cycle is deliberately dropped
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.sh_a   = {lat_a_i, lat_b_i};
            st_d.sh_b   = {lat_b_i, lat_a_i};
        end else if (st_q.active && ev_i.sclk_fall) begin
            st_d.sh_a = {st_q.sh_a[FRAME-2:0], 1'b0};
            st_d.sh_b = {st_q.sh_b[FRAME-2:0], 1'b0};
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_a_o   = st_q.active;
    assign oe_b_o   = st_q.active;
    assign dout_a_o = st_q.active & st_q.sh_a[FRAME-1];
    assign dout_b_o = st_q.active & st_q.sh_b[FRAME-1];

    AST_CS_FALL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.cs_fall |=> (oe_a_o && oe_b_o && dout_a_o == $past(lat_a_i[RES_W-1])
                          && dout_b_o == $past(lat_b_i[RES_W-1])))
        else $error("chip select fall did not present MSB"); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && ev_i.sclk_fall && !ev_i.cs_fall && !ev_i.cs_rise && st_q.cnt != CNT_MAX)
        |=> st_q.cnt == $past(st_q.cnt) + 1'b1)
        else $error("serial clock fall did not advance"); // R3

    AST_COINCIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.cs_fall && ev_i.sclk_fall) |=> st_q.cnt == '0)
        else $error("coincident serial clock fall was counted"); // R4

    AST_CS_RISE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.cs_rise |=> (!oe_a_o && !oe_b_o && !dout_a_o && !dout_b_o))
        else $error("chip select rise left a line driven"); // R6

    AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt == CNT_MAX) |-> (!dout_a_o && !dout_b_o))
        else $error("nonzero data after frame end"); // R8

endmodule

// File: rtl/adc_port_emu.sv
module adc_port_emu #(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             convst_n_i,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic [RES_W-1:0] res_a_i,
    input  logic [RES_W-1:0] res_b_i,
    output logic             busy_o,
    output logic             dout_a_o,
    output logic             oe_a_o,
    output logic             dout_b_o,
    output logic             oe_b_o
);

    import adc_port_pkg::*;

    logic [N_HOST-1:0] host_raw, host_cur, host_prev;
    port_ev_t          ev;
    logic [RES_W-1:0]  lat_a, lat_b;

    always_comb begin
        host_raw           = '1;
        host_raw[IDX_CS]   = cs_n_i;
        host_raw[IDX_SCLK] = sclk_i;
        host_raw[IDX_CONV] = convst_n_i;
    end

    adc_port_sync #(
        .W      (N_HOST),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (host_raw),
        .cur_o  (host_cur),
        .prev_o (host_prev)
    );

    always_comb begin
        ev.cs_fall   =  host_prev[IDX_CS]   & ~host_cur[IDX_CS];
        ev.cs_rise   = ~host_prev[IDX_CS]   &  host_cur[IDX_CS];
        ev.sclk_fall =  host_prev[IDX_SCLK] & ~host_cur[IDX_SCLK];
        ev.conv_fall =  host_prev[IDX_CONV] & ~host_cur[IDX_CONV];
    end

    adc_conv_timer #(
        .RES_W       (RES_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_fall_i (ev.conv_fall),
        .res_a_i     (res_a_i),
        .res_b_i     (res_b_i),
        .busy_o      (busy_o),
        .lat_a_o     (lat_a),
        .lat_b_o     (lat_b)
    );

    adc_port_shifter #(
        .RES_W (RES_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .lat_a_i  (lat_a),
        .lat_b_i  (lat_b),
        .dout_a_o (dout_a_o),
        .oe_a_o   (oe_a_o),
        .dout_b_o (dout_b_o),
        .oe_b_o   (oe_b_o)
    );

    AST_CS_DURING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.cs_fall && busy_o) |=> (oe_a_o && oe_b_o))
        else $error("chip select ignored during conversion"); // R7

endmodule

// File: tb/adc_port_emu_tb.sv
`timescale 1ns/1ps
module adc_port_emu_tb;

    localparam int RES_W = 12;
    localparam int CONV  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic convst_n = 1'b1, cs_n = 1'b1, sclk = 1'b1;
    logic [RES_W-1:0] res_a = '0, res_b = '0;
    logic busy, da, oea, db, oeb;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_port_emu #(.RES_W(RES_W), .CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst_n(rst_n), .convst_n_i(convst_n), .cs_n_i(cs_n),
        .sclk_i(sclk), .res_a_i(res_a), .res_b_i(res_b), .busy_o(busy),
        .dout_a_o(da), .oe_a_o(oea), .dout_b_o(db), .oe_b_o(oeb));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic cs_h1 = 1, cs_h2 = 1, cs_h3 = 1, sk_h1 = 1, sk_h2 = 1, sk_h3 = 1;
    logic cv_h1 = 1, cv_h2 = 1, cv_h3 = 1;
    bit   m_busy = 0, m_act = 0;
    int   m_left = 0, m_idx = 0;
    logic [RES_W-1:0] m_a = '0, m_b = '0, s_a = '0, s_b = '0;

    function automatic logic bit_at(input logic [RES_W-1:0] first, input logic [RES_W-1:0] second, input int idx);
        if (idx < RES_W)       return first[RES_W-1-idx];
        else if (idx < 2*RES_W) return second[2*RES_W-1-idx];
        else                   return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_act = 0; m_left = 0; m_idx = 0;
            m_a = '0; m_b = '0; s_a = '0; s_b = '0;
            cs_h1 = 1; cs_h2 = 1; cs_h3 = 1; sk_h1 = 1; sk_h2 = 1; sk_h3 = 1;
            cv_h1 = 1; cv_h2 = 1; cv_h3 = 1;
        end else begin
            bit csf, csr, skf, cvf;
            csf = cs_h3 && !cs_h2; csr = !cs_h3 && cs_h2;
            skf = sk_h3 && !sk_h2; cvf = cv_h3 && !cv_h2;
            if (csr) begin
                m_act = 0; m_idx = 0;
            end else if (csf) begin
                m_act = 1; m_idx = 0; s_a = m_a; s_b = m_b;
            end else if (m_act && skf && m_idx < 2*RES_W) begin
                m_idx++;
            end
            if (m_busy) begin
                if (m_left == 1) begin
                    m_busy = 0; m_a = res_a; m_b = res_b;
                end else m_left--;
            end else if (cvf) begin
                m_busy = 1; m_left = CONV;
            end
            cs_h3 = cs_h2; cs_h2 = cs_h1; cs_h1 = cs_n;
            sk_h3 = sk_h2; sk_h2 = sk_h1; sk_h1 = sclk;
            cv_h3 = cv_h2; cv_h2 = cv_h1; cv_h1 = convst_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic ea, eb;
            ea = m_act ? bit_at(s_a, s_b, m_idx) : 1'b0;
            eb = m_act ? bit_at(s_b, s_a, m_idx) : 1'b0;
            chk(busy == m_busy, "R1 busy", 32'(busy), 32'(m_busy));
            chk(oea == m_act && oeb == m_act, "R2 enables", {oea, oeb}, {m_act, m_act});
            chk(da == ea && db == eb, "R3 data lines", {da, db}, {ea, eb});
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_bits(input int nbits, output logic [31:0] wa, output logic [31:0] wb);
        wa = '0; wb = '0;
        cs_n = 1'b0;
        wait_n(4);
        wa = {wa[30:0], da}; wb = {wb[30:0], db};
        for (int i = 1; i < nbits; i++) begin
            sclk = 1'b0; wait_n(4);
            wa = {wa[30:0], da}; wb = {wb[30:0], db};
            sclk = 1'b1; wait_n(4);
        end
    endtask

    task automatic start_conv();
        convst_n = 1'b0; wait_n(4); convst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] wa, wb;
        int n;
        wait_n(3);
        // R11: reset state
        chk(!busy && !oea && !oeb, "R11 reset outputs", {busy, oea, oeb}, 0);
        rst_n = 1'b1;
        wait_n(2);
        read_bits(1, wa, wb);
        chk(wa[0] == 0 && wb[0] == 0 && oea, "R11 latched zero", {wa[0], wb[0]}, 0);
        cs_n = 1'b1; wait_n(5);

        // R1 and R9: busy length, restart ignored
        res_a = 12'hA5C; res_b = 12'h3E1;
        convst_n = 1'b0;
        n = 0;
        while (!busy && n < 10) begin wait_n(1); n++; end
        chk(n == 3, "R1 busy rise delay", n, 3);
        convst_n = 1'b1;
        n = 0;
        while (busy && n < 100) begin
            wait_n(1); n++;
            if (n == 6) convst_n = 1'b0;
            if (n == 10) convst_n = 1'b1;
        end
        chk(n == CONV, "R1 R9 busy length", n, CONV);
        wait_n(6);
        chk(!busy, "R9 no second conversion", 32'(busy), 0);

        // R10: inputs change after capture
        res_a = 12'hFFF; res_b = 12'h000;
        // R2 R3 R5 R8: chained read with four extra clocks
        read_bits(28, wa, wb);
        chk(wa[27:0] == {12'hA5C, 12'h3E1, 4'h0}, "R5 R8 R10 line A chain", wa, {4'h0, 12'hA5C, 12'h3E1, 4'h0});
        chk(wb[27:0] == {12'h3E1, 12'hA5C, 4'h0}, "R5 R8 line B chain", wb, {4'h0, 12'h3E1, 12'hA5C, 4'h0});
        chk(oea && oeb, "R8 enables held", {oea, oeb}, 2'b11);
        cs_n = 1'b1; wait_n(4);
        chk(!oea && !oeb && !da && !db, "R6 release", {oea, oeb, da, db}, 0);

        // R7: chip select during busy uses previous results
        res_a = 12'h6B7; res_b = 12'hC28;
        start_conv();
        chk(busy, "R7 busy before read", 32'(busy), 1);
        read_bits(2, wa, wb);
        chk(busy && oea && wa[1:0] == 2'b10 && wb[1:0] == 2'b00, "R7 old data while busy",
            {wa[1:0], wb[1:0]}, 4'b1000);
        cs_n = 1'b1;
        n = 0;
        while (busy && n < 100) begin wait_n(1); n++; end
        wait_n(4);

        // R4: coincident chip select and serial clock falls
        cs_n = 1'b0; sclk = 1'b0;
        wait_n(4);
        chk(da == 1'b0 && db == 1'b1, "R4 MSB kept", {da, db}, 2'b01);
        sclk = 1'b1; wait_n(4);
        sclk = 1'b0; wait_n(4);
        chk(da == 1'b1 && db == 1'b1, "R4 first counted fall", {da, db}, 2'b11);
        sclk = 1'b1; wait_n(4);
        // parallel 12-bit read of second results, restarting frame
        cs_n = 1'b1; wait_n(4);
        read_bits(12, wa, wb);
        chk(wa[11:0] == 12'h6B7 && wb[11:0] == 12'hC28, "R3 parallel read", {wa[15:0], wb[15:0]}, {16'h06B7, 16'h0C28});
        cs_n = 1'b1; wait_n(4);
        chk(!oea && !oeb, "R6 release after short read", {oea, oeb}, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule